// File: doc/BRIEF.md
# Key-Protected Configuration Lock Controller

This block guards a bank of configuration registers behind a software key. A small register port carries reads and writes. A key register sits at address 0. A control register sits at address 1. The protected bank takes the addresses after those two. Writing the opening key to the key register starts a write session, and the block then passes write enables to the protected bank. Writing any other key ends the session, and later protected writes are dropped without any error response. Reads of the protected bank are let through whether or not a session is open.

After a hard reset only one session is allowed. Software can ask for more by setting the re-open bit in the control register while a session is open. The block samples that bit when the session closes. If it is 0 then, the block locks until the next hard reset. If it is 1, a later correct key opens a new session.

Top module: `cfg_lock_gate`

## Requirements
- R1: A read of address 0 (key register) returns 16'h96A5 on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read. This holds whatever was last written there.
- R2: Writing 16'h2D52 to address 0 opens a session if no session has been used since reset. `lock_o` reads 0 from the next cycle. A further 16'h2D52 written while the session is open leaves it open.
- R3: Writing any value other than 16'h2D52 to address 0 while a session is open closes it. `lock_o` reads 1 from the next cycle, and protected writes are blocked from then on.
- R4: `prot_we` is high in the same cycle as a valid write to a protected address (2 up to 2+NUM_PROT-1) only while a session is open. It stays low for writes while locked and for writes to unmapped addresses.
- R5: `prot_re` is high in the same cycle as a valid read of a protected address, whatever the lock state.
- R6: Reading address 1 returns bit 0 as the re-open bit and bit 1 as the lock status (1 = locked), with all other bits 0. The lock status equals `lock_o`.
- R7: If the re-open bit is 0 when the first session closes, a later 16'h2D52 is ignored and `lock_o` stays 1 until a hard reset.
- R8: If the re-open bit is set to 1 during the first session, a 16'h2D52 written after that session has closed opens a new session.
- R9: If the re-open bit is cleared during a later session, no session can open after that session closes.
- R10: A write to address 1 while locked is dropped. The re-open bit read back afterwards is unchanged.
- R11: After a hard reset the block is locked (`lock_o` = 1), no session has been used, and the re-open bit is 0. Address 1 reads 16'h0002.
- R12: A wrong key written while locked changes nothing. `lock_o` stays 1, and the first session can still be opened afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously inside |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for addresses 0 and 1, zero for others |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| prot_we | output | 1 | Gated write enable to the protected bank |
| prot_re | output | 1 | Read enable to the protected bank |
| lock_o | output | 1 | 1 while protected writes are blocked |

## Verification
`prot_we` and `prot_re` are combinational, so the bench samples them 1 ns after it drives an access, before the clock edge. A session change caused by a key write shows on `lock_o` one cycle later, and the bench checks it at the falling edge after the write's rising edge. Read data is due one cycle after a read. The driver pushes each expected word into a queue when it issues the read. A monitor pops one entry at every falling edge where `bus_rvalid` is high and compares it, so results are matched in order and at their due cycle.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int          KEY_W    = 16;
  localparam logic [15:0] KEY_SIG  = 16'h96A5;
  localparam logic [15:0] KEY_OPEN = 16'h2D52;
  localparam int          ADDR_KEY  = 0;
  localparam int          ADDR_CTRL = 1;
  localparam int          PROT_BASE = 2;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_PROT = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_PROT = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  localparam logic [31:0] PROT_END = 32'(PROT_BASE + NUM_PROT);
  logic [31:0] addr_wide;

  assign addr_wide = 32'(addr);

  always_comb begin
    if (addr_wide == 32'(ADDR_KEY))       sel = SEL_KEY;
    else if (addr_wide == 32'(ADDR_CTRL)) sel = SEL_CTRL;
    else if (addr_wide < PROT_END)        sel = SEL_PROT;
    else                                  sel = SEL_NONE;
  end
endmodule

// File: rtl/cfg_lock_session.sv
module cfg_lock_session
  import cfg_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             ctrl_wr,
  input  logic             ctrl_recfg,
  output logic             open_o,
  output logic             recfg_o
);
  logic open_q, used_q, reopen_q, recfg_q;
  logic open_d, used_d, reopen_d, recfg_d;
  logic key_ok, state_en;

  assign key_ok   = (key_val == KEY_OPEN);
  assign state_en = key_wr | ctrl_wr;

  always_comb begin
    open_d   = open_q;
    used_d   = used_q;
    reopen_d = reopen_q;
    recfg_d  = recfg_q;
    if (key_wr) begin
      if (open_q && !key_ok) begin
        open_d   = 1'b0;
        used_d   = 1'b1;
        reopen_d = recfg_q;
      end else if (!open_q && key_ok && (!used_q || reopen_q)) begin
        open_d = 1'b1;
      end
    end
    if (ctrl_wr && open_q) recfg_d = ctrl_recfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      used_q   <= 1'b0;
      reopen_q <= 1'b0;
      recfg_q  <= 1'b0;
    end else if (state_en) begin
      open_q   <= open_d;
      used_q   <= used_d;
      reopen_q <= reopen_d;
      recfg_q  <= recfg_d;
    end
  end

  assign open_o  = open_q;
  assign recfg_o = recfg_q;

  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && open_q && !key_ok |=> !open_q); // R3
  AST_FIRST_SESSION_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_ok && !used_q |=> open_q); // R2
  AST_PERM_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    used_q && !reopen_q && !open_q |=> !open_q); // R7
  AST_RECFG_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> $stable(recfg_q)); // R10
endmodule

// File: rtl/cfg_lock_rdmux.sv
module cfg_lock_rdmux
  import cfg_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  sel_e             sel,
  input  logic             recfg,
  input  logic             locked,
  output logic [KEY_W-1:0] rdata,
  output logic             rvalid
);
  logic [KEY_W-1:0] rdata_d, rdata_q;
  logic             rvalid_q;

  always_comb begin
    unique case (sel)
      SEL_KEY:  rdata_d = KEY_SIG;
      SEL_CTRL: rdata_d = {{(KEY_W-2){1'b0}}, locked, recfg};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_PROT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              prot_we,
  output logic              prot_re,
  output logic              lock_o
);
  logic rst_meta, rst_sync;
  sel_e sel;
  logic wr_acc, rd_acc, key_wr, ctrl_wr, sess_open, recfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cfg_lock_decode #(.ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_acc  = bus_valid & bus_write;
  assign rd_acc  = bus_valid & ~bus_write;
  assign key_wr  = wr_acc & (sel == SEL_KEY);
  assign ctrl_wr = wr_acc & (sel == SEL_CTRL);

  cfg_lock_session u_session (
    .clk        (clk),
    .rst_n      (rst_sync),
    .key_wr     (key_wr),
    .key_val    (bus_wdata),
    .ctrl_wr    (ctrl_wr),
    .ctrl_recfg (bus_wdata[0]),
    .open_o     (sess_open),
    .recfg_o    (recfg)
  );

  assign lock_o  = ~sess_open;
  assign prot_we = wr_acc & (sel == SEL_PROT) & sess_open;
  assign prot_re = rd_acc & (sel == SEL_PROT);

  cfg_lock_rdmux u_rdmux (
    .clk    (clk),
    .rst_n  (rst_sync),
    .rd_en  (rd_acc),
    .sel    (sel),
    .recfg  (recfg),
    .locked (lock_o),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  AST_KEY_SIGNATURE: assert property (@(posedge clk) disable iff (!rst_sync)
    bus_rvalid && $past(sel == SEL_KEY) |-> bus_rdata == KEY_SIG); // R1
endmodule

// File: tb/cfg_lock_gate_bench.sv
module cfg_lock_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, prot_we, prot_re, lock_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        we_seen, re_seen;

  always #2.5 clk = ~clk;

  cfg_lock_gate u_cfg_lock_gate (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .prot_we(prot_we), .prot_re(prot_re), .lock_o(lock_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    #1;
    we_seen = prot_we; re_seen = prot_re;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    access(1'b0, a, 16'h0);
  endtask

  task automatic chk_lock(input logic exp, input string tag);
    @(negedge clk);
    check(tag, {15'b0, lock_o}, {15'b0, exp});
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R1: unexpected read data %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    hard_reset();
    chk_lock(1'b1, "R11 lock after reset");
    rd(4'd1, 16'h0002, "R11 ctrl after reset");
    rd(4'd0, 16'h96A5, "R1 key signature");
    access(1'b1, 4'd3, 16'hBEEF);
    check("R4 we while locked", {15'b0, we_seen}, 16'h0);
    rd(4'd3, 16'h0000, "R5 prot read data locked");
    check("R5 re while locked", {15'b0, re_seen}, 16'h1);
    access(1'b1, 4'd0, 16'h1234);
    chk_lock(1'b1, "R12 wrong key while locked");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b0, "R2 first session opens");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b0, "R2 correct key keeps open");
    access(1'b1, 4'd0, 16'hFFFF);
    chk_lock(1'b1, "R12 wrong key closes no-use session? no, R3 closes");
    hard_reset();
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b0, "R12 first session still available");
    access(1'b1, 4'd0, 16'h2D52);
    rd(4'd0, 16'h96A5, "R1 key after open key written");
    rd(4'd1, 16'h0000, "R6 ctrl while open");
    access(1'b1, 4'd5, 16'h00AA);
    check("R4 we while open", {15'b0, we_seen}, 16'h1);
    rd(4'd9, 16'h0000, "R5 prot read data open");
    check("R5 re while open", {15'b0, re_seen}, 16'h1);
    access(1'b1, 4'd12, 16'h0001);
    check("R4 we unmapped", {15'b0, we_seen}, 16'h0);
    access(1'b1, 4'd0, 16'h0000);
    chk_lock(1'b1, "R3 bad key closes");
    access(1'b1, 4'd5, 16'h0055);
    check("R3 we after close", {15'b0, we_seen}, 16'h0);
    rd(4'd1, 16'h0002, "R6 ctrl lock bit");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b1, "R7 second key ignored");
    access(1'b1, 4'd1, 16'h0001);
    rd(4'd1, 16'h0002, "R10 ctrl write while locked dropped");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b1, "R7 still locked");
    hard_reset();
    access(1'b1, 4'd0, 16'h2D52);
    access(1'b1, 4'd1, 16'h0001);
    rd(4'd1, 16'h0001, "R8 reopen bit set");
    access(1'b1, 4'd0, 16'h5A5A);
    chk_lock(1'b1, "R3 close first session");
    rd(4'd1, 16'h0003, "R6 ctrl locked with reopen");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b0, "R8 second session opens");
    access(1'b1, 4'd1, 16'h0000);
    access(1'b1, 4'd0, 16'h0001);
    chk_lock(1'b1, "R9 later session closes");
    access(1'b1, 4'd0, 16'h2D52);
    chk_lock(1'b1, "R9 no session after clearing");
    access(1'b1, 4'd7, 16'h1111);
    check("R9 we blocked", {15'b0, we_seen}, 16'h0);
    repeat (4) @(negedge clk);
    check("R1 all reads returned", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL R2: watchdog expired, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule